// File: doc/BRIEF.md
# ADC Conversion Control

This block sits between a processor bus and an analog-to-digital conversion engine. Software programs one control register that holds three fields: a busy/start bit, a clock-speed select and an input-mode select. Setting the busy bit starts the prescaler, which paces a fixed-length conversion in conversion-clock ticks. On the last tick the block stores a 10-bit result in two readable registers and clears the busy bit. The analog front end is modelled by a digital sample input, which is latched on the first conversion tick.

Control is deliberately narrow. Writing 0 to the busy bit is the only way to abort, and writing 1 is the only way to start. Writing 1 while a conversion is running is ignored, so a restart takes a write of 0 followed by a write of 1, and the block honours such a pair on consecutive clocks. The result is split into a high byte and a left-justified two-bit low register whose unused bits read as zero. Both result registers can also be written from the bus. They keep their value until a conversion completes.

Top module: `adc_conv_ctrl`

## Requirements
- R1: The control register is at address 0. Bit 0 is busy, bit 1 is the clock select (1 = undivided, 0 = divided by 16) and bit 2 is the mode (0 = single-ended, 1 = differential). Bits 7 to 3 read as 0.
- R2: While a conversion runs, `cclk_tick` pulses on every clock when the captured clock select is 1. When it is 0, `cclk_tick` pulses once every 16 clocks, and the first pulse falls in the 16th busy cycle.
- R3: While busy is 0, `cclk_tick` stays low and the prescaler is held cleared.
- R4: A write with bit 0 set while idle starts a conversion. That write captures the clock select and mode. `conv_diff` shows the captured mode for the whole conversion.
- R5: A conversion lasts 12 ticks. The sample is latched on the first tick. On the last tick the result is stored and busy clears on the same edge, so `conv_active` stays high for 12 clocks when undivided and 192 clocks when divided.
- R6: Writing 0 to the busy bit during a conversion aborts it. Busy and ticks stop from the next cycle, and the result registers do not change.
- R7: A write of 0 followed on the next clock by a write of 1 restarts the conversion from its first tick with a freshly latched sample.
- R8: Writing 1 to the busy bit while busy is 1 has no effect on the running conversion or its length.
- R9: Address 1 reads result bits 9 to 2. Address 2 reads result bits 1 to 0 in its bits 7 to 6, and its bits 5 to 0 always read 0. Address 3 reads 0.
- R10: The bus can write the result registers (address 1 takes the whole byte, address 2 takes bits 7 to 6). They hold their value until a completed conversion overwrites them, and a completion wins over a bus write in the same cycle.
- R11: After reset the control register and both result registers read 0.
- R12: An abort write in the same cycle as the last tick wins: busy clears and the result registers are not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register select: 0 control, 1 result high, 2 result low |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| smp_data | input | 10 | Digital stand-in for the analog sample |
| cclk_tick | output | 1 | One-clock conversion clock pulse |
| conv_active | output | 1 | Busy bit: a conversion is in progress |
| conv_diff | output | 1 | Mode captured for the running conversion |

## Verification
A prescaler counter that runs off phase or is not cleared while idle shows up on `cclk_tick` within one pulse period. That is at most 16 clocks. A wrong tick count inside the sequencer appears as a wrong `conv_active` length, or as a result latched from the wrong sample, as soon as the conversion ends. A busy flag that mishandles abort, restart or a redundant start is visible on `conv_active` in the very next cycle. A result-register priority fault appears on the next read of address 1 or 2.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RHI  = 2'd1,
    REG_RLO  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_FAST = 1;
  localparam int unsigned BIT_DIFF = 2;
  localparam int unsigned CTRL_W   = 3;

  typedef struct packed {
    logic diff;
    logic fast;
    logic busy;
  } ctrl_t;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);

  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = en && (fast || (cnt_q == CNT_LAST));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  // R2
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !fast && tick |=> !tick);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned CONV_TICKS = 12,
  parameter int unsigned RES_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [RES_W-1:0] smp,
  output logic             done,
  output logic [RES_W-1:0] hold
);

  localparam int unsigned TW = $clog2(CONV_TICKS);
  localparam logic [TW-1:0] T_LAST = TW'(CONV_TICKS - 1);

  logic [TW-1:0]    tcnt_q;
  logic [TW-1:0]    tcnt_d;
  logic [RES_W-1:0] hold_q;
  logic [RES_W-1:0] hold_d;
  logic             first_tick;

  assign first_tick = tick && (tcnt_q == '0);
  assign done       = tick && (tcnt_q == T_LAST);

  always_comb begin
    tcnt_d = tcnt_q;
    if (clear) begin
      tcnt_d = '0;
    end else if (tick) begin
      tcnt_d = (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (first_tick) begin
      hold_d = smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      hold_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      hold_q <= hold_d;
    end
  end

  assign hold = hold_q;

  // R3
  no_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !done);

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [RES_W-1:0]          value,
  input  logic                      wr_hi,
  input  logic                      wr_lo,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         res_hi,
  output logic [RES_W-DATA_W-1:0]   res_lo
);

  localparam int unsigned LO_W = RES_W - DATA_W;

  logic [DATA_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0]   lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (load) begin
      hi_d = value[RES_W-1 -: DATA_W];
      lo_d = value[LO_W-1:0];
    end else begin
      if (wr_hi) hi_d = wdata;
      if (wr_lo) lo_d = wdata[DATA_W-1 -: LO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;

  // R10
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !wr_hi |=> $stable(hi_q));

  // R10
  hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !wr_lo |=> $stable(lo_q));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RES_W       = 10,
  parameter int unsigned CONV_TICKS  = 12,
  parameter int unsigned SLOW_DIV    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RES_W-1:0]  smp_data,
  output logic              cclk_tick,
  output logic              conv_active,
  output logic              conv_diff
);

  localparam int unsigned LO_W     = RES_W - DATA_W;
  localparam int unsigned PAD_W    = DATA_W - LO_W;
  localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;

  logic       rst_sync_n;
  reg_sel_e   sel;
  ctrl_t      ctrl_q, ctrl_d;
  logic       snap_fast_q, snap_fast_d;
  logic       snap_diff_q, snap_diff_d;
  logic       wr_ctrl, start_w, abort_w, finish_w;
  logic       tick_w, seq_done;
  logic [RES_W-1:0]  seq_hold;
  logic [DATA_W-1:0] res_hi;
  logic [LO_W-1:0]   res_lo;

  adc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
  assign start_w  = wr_ctrl && bus_wdata[BIT_BUSY] && !ctrl_q.busy;
  assign abort_w  = wr_ctrl && !bus_wdata[BIT_BUSY] && ctrl_q.busy;
  assign finish_w = seq_done && !abort_w;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.fast = bus_wdata[BIT_FAST];
      ctrl_d.diff = bus_wdata[BIT_DIFF];
    end
    if (start_w) begin
      ctrl_d.busy = 1'b1;
    end else if (abort_w || finish_w) begin
      ctrl_d.busy = 1'b0;
    end
  end

  always_comb begin
    snap_fast_d = snap_fast_q;
    snap_diff_d = snap_diff_q;
    if (start_w) begin
      snap_fast_d = bus_wdata[BIT_FAST];
      snap_diff_d = bus_wdata[BIT_DIFF];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q      <= '0;
      snap_fast_q <= 1'b0;
      snap_diff_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      snap_fast_q <= snap_fast_d;
      snap_diff_q <= snap_diff_d;
    end
  end

  adc_prescaler #(.SLOW_DIV(SLOW_DIV)) u_psc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ctrl_q.busy),
    .fast  (snap_fast_q),
    .tick  (tick_w)
  );

  adc_conv_seq #(.CONV_TICKS(CONV_TICKS), .RES_W(RES_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (!ctrl_q.busy),
    .tick  (tick_w),
    .smp   (smp_data),
    .done  (seq_done),
    .hold  (seq_hold)
  );

  adc_result_regs #(.RES_W(RES_W), .DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (finish_w),
    .value  (seq_hold),
    .wr_hi  (bus_wr && (sel == REG_RHI)),
    .wr_lo  (bus_wr && (sel == REG_RLO)),
    .wdata  (bus_wdata),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      REG_RHI:  bus_rdata = res_hi;
      REG_RLO:  bus_rdata = {res_lo, {PAD_W{1'b0}}};
      default:  bus_rdata = '0;
    endcase
  end

  assign cclk_tick   = tick_w;
  assign conv_active = ctrl_q.busy;
  assign conv_diff   = snap_diff_q;

  // R9
  always_comb begin
    if (sel == REG_RLO) begin
      lo_pad_chk: assert (bus_rdata[PAD_W-1:0] == '0);
    end
  end

  // R4
  start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ctrl_q.busy) |-> $past(bus_wr && (bus_addr == 2'd0) && bus_wdata[BIT_BUSY]));

  // R6
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_w |=> !conv_active && !cclk_tick);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q.busy && wr_ctrl && bus_wdata[BIT_BUSY] && !seq_done |=> conv_active && $stable(conv_diff));

  // R5
  finish_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    finish_w |=> !conv_active);

  // R12
  abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_done && abort_w |=> $stable(res_hi) && $stable(res_lo));

endmodule

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [9:0] smp_data;
  logic       cclk_tick, conv_active, conv_diff;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  adc_conv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_data(smp_data),
    .cclk_tick(cclk_tick), .conv_active(conv_active), .conv_diff(conv_diff)
  );

  // behavioural reference state
  bit m_busy, m_fast, m_diff, m_sfast, m_sdiff;
  int m_div, m_tk, m_hold, m_hi, m_lo;

  function automatic bit m_tick();
    return m_busy && (m_sfast || m_div == 15);
  endfunction

  function automatic int m_rd(input int a);
    case (a)
      0: return {m_diff, m_fast, m_busy};
      1: return m_hi;
      2: return m_lo << 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_busy, m_fast, m_diff, m_sfast, m_sdiff} = '0;
      m_div = 0; m_tk = 0; m_hold = 0; m_hi = 0; m_lo = 0;
    end else begin
      bit t, wrc, st, ab, dn, fin;
      t   = m_tick();
      wrc = bus_wr && bus_addr == 0;
      st  = wrc && bus_wdata[0] && !m_busy;
      ab  = wrc && !bus_wdata[0] && m_busy;
      dn  = t && m_tk == 11;
      fin = dn && !ab;
      if (fin) begin
        m_hi = m_hold / 4;
        m_lo = m_hold % 4;
      end else if (bus_wr && bus_addr == 1) m_hi = bus_wdata;
      else if (bus_wr && bus_addr == 2) m_lo = bus_wdata[7:6];
      if (t && m_tk == 0) m_hold = smp_data;
      if (!m_busy) m_tk = 0; else if (t) m_tk = (m_tk == 11) ? 0 : m_tk + 1;
      if (!m_busy) m_div = 0; else m_div = (m_div == 15) ? 0 : m_div + 1;
      if (wrc) begin m_fast = bus_wdata[1]; m_diff = bus_wdata[2]; end
      if (st) begin m_sfast = bus_wdata[1]; m_sdiff = bus_wdata[2]; m_busy = 1; end
      else if (ab || fin) m_busy = 0;
    end
  end

  // cycle compare against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (cclk_tick !== m_tick()) begin
        failures++;
        $display("FAIL R2 tick: actual=%0b expected=%0b t=%0t", cclk_tick, m_tick(), $time);
      end
      if (conv_active !== m_busy) begin
        failures++;
        $display("FAIL R5 busy: actual=%0b expected=%0b t=%0t", conv_active, m_busy, $time);
      end
      if (conv_diff !== m_sdiff) begin
        failures++;
        $display("FAIL R4 mode: actual=%0b expected=%0b t=%0t", conv_diff, m_sdiff, $time);
      end
      if (bus_rdata !== 8'(m_rd(bus_addr))) begin
        failures++;
        $display("FAIL %s rdata: actual=%0h expected=%0h t=%0t",
                 bus_addr == 0 ? "R1" : "R9", bus_rdata, m_rd(bus_addr), $time);
      end
    end
  end

  // busy run-length monitor
  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (conv_active) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 2'(a);
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (conv_active && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0; smp_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(0, v); chk("R11 ctrl", v, 0);
    rd(1, v); chk("R11 hi", v, 0);
    rd(2, v); chk("R11 lo", v, 0);

    // R10 R9 bus-written results, low padding
    wr(1, 8'hA5); wr(2, 8'hFF);
    rd(1, v); chk("R10 hi write", v, 8'hA5);
    rd(2, v); chk("R9 lo pad", v, 8'hC0);
    rd(3, v); chk("R9 unused addr", v, 0);

    // R1 field readback, upper bits zero
    wr(0, 8'hFE);
    rd(0, v); chk("R1 ctrl bits", v, 8'h06);

    // R5 R4 fast differential conversion, sample latched on first tick
    smp_data = 10'h2D7;
    wr(0, 8'h07);
    @(negedge clk); smp_data = 10'h000;
    wait_idle();
    chk("R5 fast length", last_run, 12);
    rd(1, v); chk("R5 result hi", v, 8'hB5);
    rd(2, v); chk("R9 result lo", v, 8'hC0);
    rd(0, v); chk("R5 busy cleared", v, 8'h06);

    // R2 divided clock
    smp_data = 10'h155;
    wr(0, 8'h01);
    wait_idle();
    chk("R2 slow length", last_run, 192);
    rd(1, v); chk("R2 result hi", v, 8'h55);
    rd(2, v); chk("R2 result lo", v, 8'h40);

    // R8 redundant start ignored
    smp_data = 10'h3FF;
    wr(0, 8'h03);
    repeat (3) @(negedge clk);
    wr(0, 8'h03);
    wait_idle();
    chk("R8 length", last_run, 12);
    rd(1, v); chk("R8 result hi", v, 8'hFF);

    // R6 abort keeps results, R3 no ticks while idle
    wr(1, 8'h12); wr(2, 8'h40);
    smp_data = 10'h000;
    wr(0, 8'h03);
    repeat (4) @(negedge clk);
    wr(0, 8'h02);
    #1 chk("R6 busy off", conv_active, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk("R3 no tick", cclk_tick, 0);
    end
    rd(1, v); chk("R6 hi kept", v, 8'h12);
    rd(2, v); chk("R6 lo kept", v, 8'h40);

    // R7 clear-then-set on consecutive clocks
    smp_data = 10'h111;
    wr(0, 8'h03);
    repeat (5) @(negedge clk);
    smp_data = 10'h2AA;
    @(negedge clk);
    bus_addr = 0; bus_wdata = 8'h02; bus_wr = 1;
    @(negedge clk);
    bus_wdata = 8'h03;
    @(negedge clk);
    bus_wr = 0;
    #1 chk("R7 restarted", conv_active, 1);
    wait_idle();
    chk("R7 length", last_run, 12);
    rd(1, v); chk("R7 result hi", v, 8'hAA);
    rd(2, v); chk("R7 result lo", v, 8'h80);

    // R12 abort on the final tick wins
    wr(1, 8'h33); wr(2, 8'h00);
    smp_data = 10'h3C3;
    @(negedge clk);
    bus_addr = 0; bus_wdata = 8'h03; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    repeat (11) @(negedge clk);
    bus_addr = 0; bus_wdata = 8'h02; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    #1 chk("R12 busy off", conv_active, 0);
    rd(1, v); chk("R12 hi kept", v, 8'h33);
    rd(2, v); chk("R12 lo kept", v, 8'h00);

    // R10 completion beats a same-cycle bus write
    smp_data = 10'h0F6;
    @(negedge clk);
    bus_addr = 0; bus_wdata = 8'h03; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    repeat (11) @(negedge clk);
    bus_addr = 1; bus_wdata = 8'h77; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    rd(1, v); chk("R10 completion wins", v, 8'h3D);
    rd(2, v); chk("R10 lo from result", v, 8'h80);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule